// File: doc/BRIEF.md
# Masked Vector Unsigned-64 to Binary32 Converter

This unit converts a vector of unsigned 64-bit integers into IEEE-754 single-precision values in one registered step. The source holds 2, 4 or 8 lanes, depending on the selected vector length. Results are packed into 32-bit lanes, so the result occupies half as many bits as the source. A per-lane write mask selects which lanes take a new value. A lane that is masked off either keeps the matching lane of the old destination or is cleared, depending on a mode input. Every destination bit above the result is cleared.

Every conversion rounds exactly, using one of four rounding modes. The mode normally comes from a global setting. At the widest vector length, with a register-style source, an embedded per-operation field can override it. A memory-style source with the broadcast bit set feeds the lowest 64-bit element to every lane. The unit raises an inexact flag for the active lanes. An operation whose auxiliary specifier field is not all ones is rejected: the unit raises an undefined-operation flag and returns the old destination untouched.

Top module: `uq2sp_vec`

## Requirements
- R1: `out_valid` rises exactly one clock after `in_valid`. Result lane j (`dst[32j+31:32j]`) is the binary32 form of source element j (`src[64j+63:64j]`). The sign bit is always 0, and an input of 0 gives 32'h0000_0000.
- R2: Rounding is exact, with mode codes 00 = nearest-even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero. A rounding carry raises the exponent, so 2^64-1 under nearest-even gives 32'h5F80_0000.
- R3: With `mask_en` = 0 every lane within the vector length is active. With `mask_en` = 1, lane j is active only when `mask[j]` = 1.
- R4: An inactive lane within the vector length takes the matching lane of `old_dst` when `zero_mode` = 0, and takes 0 when `zero_mode` = 1.
- R5: `vlen` 00 selects 2 lanes, 01 selects 4 lanes, and 10 or 11 selects 8 lanes. All `dst` bits at and above 32 times the lane count are 0.
- R6: The rounding mode is `rc_embed` when `vlen` selects 8 lanes, `bcast_rc` = 1 and `src_is_mem` = 0. In every other case it is `rc_global`.
- R7: When `src_is_mem` = 1 and `bcast_rc` = 1, every active lane converts `src[63:0]`.
- R8: When `spec` is not 4'hF, the result has `undef` = 1, `dst` equal to the old destination and `inexact` = 0. When `spec` is 4'hF, `undef` = 0.
- R9: `inexact` is the OR, over the active lanes only, of "the converted value differs from the integer".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| vlen | input | 2 | Vector length code |
| src | input | 512 | Packed unsigned 64-bit source elements |
| old_dst | input | 256 | Previous destination contents |
| mask_en | input | 1 | Write mask in use |
| mask | input | 8 | Per-lane write mask |
| zero_mode | input | 1 | 1 = clear inactive lanes, 0 = keep them |
| bcast_rc | input | 1 | Broadcast / rounding-override bit |
| src_is_mem | input | 1 | Source is memory-style |
| rc_embed | input | 2 | Embedded rounding mode |
| rc_global | input | 2 | Global rounding mode |
| spec | input | 4 | Auxiliary specifier, must be 4'hF |
| out_valid | output | 1 | Result valid |
| dst | output | 256 | Packed binary32 result |
| inexact | output | 1 | Precision flag |
| undef | output | 1 | Illegal-encoding flag |

## Verification
The bit `bcast_rc` drives two functions: it asks for broadcast when the source is memory-style, and it allows the rounding override when the source is a register. The bench sets it with `src_is_mem` toggled while the embedded and global modes differ. A correct result then shows broadcast with global rounding in one case, and per-lane sources with embedded rounding in the other. Inexact lanes are also placed under a clear mask bit in the same operation as exact active lanes, so that `inexact` must come only from the active lanes. Every result is compared with a behavioural reference that rounds through integer division and remainder.

// File: rtl/uq2sp_vec.sv
module uq2sp_vec #(
  parameter int LANES = 8,
  localparam int SW = 64 * LANES,
  localparam int DW = 32 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    vlen,
  input  logic [SW-1:0] src,
  input  logic [DW-1:0] old_dst,
  input  logic          mask_en,
  input  logic [LANES-1:0] mask,
  input  logic          zero_mode,
  input  logic          bcast_rc,
  input  logic          src_is_mem,
  input  logic [1:0]    rc_embed,
  input  logic [1:0]    rc_global,
  input  logic [3:0]    spec,
  output logic          out_valid,
  output logic [DW-1:0] dst,
  output logic          inexact,
  output logic          undef
);

  function automatic logic [32:0] cvt(input logic [63:0] x, input logic [1:0] rm);
    int p;
    logic [23:0] sig;
    logic [24:0] s2;
    logic [63:0] lowm;
    logic g, st, up;
    logic [7:0] e;
    p = 0;
    for (int b = 0; b < 64; b++) if (x[b]) p = b;
    if (x == 64'd0) return 33'd0;
    if (p <= 23) begin
      sig = 24'(x << (23 - p));
      return {1'b0, 1'b0, 8'(127 + p), sig[22:0]};
    end
    sig  = 24'(x >> (p - 23));
    g    = x[p-24];
    lowm = (64'd1 << (p - 24)) - 64'd1;
    st   = |(x & lowm);
    case (rm)
      2'b00:   up = g & (st | sig[0]);
      2'b10:   up = g | st;
      default: up = 1'b0;
    endcase
    s2 = {1'b0, sig} + {24'd0, up};
    e  = 8'(127 + p);
    if (s2[24]) begin
      e  = e + 8'd1;
      s2 = s2 >> 1;
    end
    return {g | st, 1'b0, e, s2[22:0]};
  endfunction

  logic [3:0]    kl;
  logic [1:0]    rm;
  logic [DW-1:0] nxt_dst;
  logic          nxt_inx;

  assign kl = (vlen == 2'd0) ? 4'd2 : (vlen == 2'd1) ? 4'd4 : 4'd8;
  assign rm = (vlen[1] && bcast_rc && !src_is_mem) ? rc_embed : rc_global;

  always_comb begin
    nxt_dst = '0;
    nxt_inx = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      logic [63:0] el;
      logic [32:0] r;
      el = (src_is_mem && bcast_rc) ? src[63:0] : src[64*j +: 64];
      r  = cvt(el, rm);
      if (j < int'(kl)) begin
        if (!mask_en || mask[j]) begin
          nxt_dst[32*j +: 32] = r[31:0];
          nxt_inx = nxt_inx | r[32];
        end else if (!zero_mode) begin
          nxt_dst[32*j +: 32] = old_dst[32*j +: 32];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      inexact   <= 1'b0;
      undef     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef   <= (spec != 4'hF);
        dst     <= (spec != 4'hF) ? old_dst : nxt_dst;
        inexact <= (spec == 4'hF) && nxt_inx;
      end
    end
  end

endmodule

module uq2sp_vec_chk #(
  parameter int LANES = 8,
  localparam int SW = 64 * LANES,
  localparam int DW = 32 * LANES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    vlen,
  input logic [DW-1:0] old_dst,
  input logic          mask_en,
  input logic [LANES-1:0] mask,
  input logic          zero_mode,
  input logic [3:0]    spec,
  input logic          out_valid,
  input logic [DW-1:0] dst,
  input logic          inexact,
  input logic          undef
);

  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_reject_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && undef) |-> (dst == $past(old_dst) && !inexact));

  assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (undef == ($past(spec) != 4'hF)));

  assert_upper_zero2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !undef && $past(vlen) == 2'd0) |-> dst[DW-1:64] == '0);

  assert_upper_zero4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !undef && $past(vlen) == 2'd1) |-> dst[DW-1:128] == '0);

  assert_merge_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !undef && $past(mask_en) && !$past(mask[0]) && !$past(zero_mode))
      |-> dst[31:0] == $past(old_dst[31:0]));

  assert_zero_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !undef && $past(mask_en) && !$past(mask[0]) && $past(zero_mode))
      |-> dst[31:0] == 32'd0);

endmodule

bind uq2sp_vec uq2sp_vec_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_uq2sp_vec.sv
`timescale 1ns/1ps
module sim_uq2sp_vec;
  logic         clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0]   vlen = 0, rc_embed = 0, rc_global = 0;
  logic [511:0] src = 0;
  logic [255:0] old_dst = 0;
  logic         mask_en = 0, zero_mode = 0, bcast_rc = 0, src_is_mem = 0;
  logic [7:0]   mask = 0;
  logic [3:0]   spec = 4'hF;
  logic         out_valid, inexact, undef;
  logic [255:0] dst;
  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  uq2sp_vec u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [32:0] ref_cvt(input logic [63:0] x, input logic [1:0] rm);
    logic [64:0] xv, step, t, rem, v;
    int q, q2;
    logic up;
    logic [22:0] man;
    if (x == 0) return 33'd0;
    xv = {1'b0, x};
    q = 0;
    for (int b = 0; b < 64; b++) if (x[b]) q = b;
    if (q <= 23) begin
      man = 23'(xv << (23 - q));
      return {1'b0, 1'b0, 8'(127 + q), man};
    end
    step = 65'd1 << (q - 23);
    t    = (xv / step) * step;
    rem  = xv - t;
    case (rm)
      2'b00: up = (rem > step / 2) || (rem == step / 2 && ((t / step) % 2 == 1));
      2'b10: up = (rem != 0);
      default: up = 1'b0;
    endcase
    v = up ? t + step : t;
    q2 = 0;
    for (int b = 0; b < 65; b++) if (v[b]) q2 = b;
    man = 23'(v >> (q2 - 23));
    return {rem != 0, 1'b0, 8'(127 + q2), man};
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [1:0] vl, logic me, logic [7:0] mk, logic zm,
                     logic bc, logic mem, logic [1:0] rce, logic [1:0] rcg, logic [3:0] sp);
    logic [255:0] ed;
    logic ei;
    int kl;
    logic [1:0] rm;
    kl = (vl == 0) ? 2 : (vl == 1) ? 4 : 8;
    rm = (kl == 8 && bc && !mem) ? rce : rcg;
    ed = '0; ei = 0;
    for (int j = 0; j < kl; j++) begin
      logic [32:0] r;
      r = ref_cvt((mem && bc) ? src[63:0] : src[64*j +: 64], rm);
      if (!me || mk[j]) begin ed[32*j +: 32] = r[31:0]; ei |= r[32]; end
      else if (!zm) ed[32*j +: 32] = old_dst[32*j +: 32];
    end
    if (sp != 4'hF) begin ed = old_dst; ei = 0; end
    @(negedge clk);
    vlen = vl; mask_en = me; mask = mk; zero_mode = zm; bcast_rc = bc;
    src_is_mem = mem; rc_embed = rce; rc_global = rcg; spec = sp; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid"}, {255'd0, out_valid}, 256'd1);
    check({tag, " dst"}, dst, ed);
    check({tag, " inexact"}, {255'd0, inexact}, {255'd0, ei});
    check({tag, " undef"}, {255'd0, undef}, {255'd0, (sp != 4'hF)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {255'd0, out_valid}, 256'd0);
    check("R1 reset dst", dst, 256'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle valid", {255'd0, out_valid}, 256'd0);

    src = {64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0100_0001, 64'h0100_0003,
           64'h8000_0000_0000_0001, 64'h0000_00FF_FFFF_FF80, 64'd1, 64'd0};
    old_dst = {8{32'hA5A5_5A5A}};
    run("R1 R2 R9 rne", 2'd2, 0, 8'h00, 0, 0, 0, 2'd0, 2'd0, 4'hF);
    check("R1 zero lane", {224'd0, dst[31:0]}, 256'd0);
    check("R1 one lane", {224'd0, dst[63:32]}, {224'd0, 32'h3F80_0000});
    check("R2 carry lane", {224'd0, dst[223:192]}, {224'd0, 32'h5F80_0000});
    run("R2 down", 2'd2, 0, 8'h00, 0, 0, 0, 2'd0, 2'd1, 4'hF);
    run("R2 up", 2'd2, 0, 8'h00, 0, 0, 0, 2'd0, 2'd2, 4'hF);
    run("R2 trunc", 2'd3, 0, 8'h00, 0, 0, 0, 2'd0, 2'd3, 4'hF);
    check("R2 trunc max", {224'd0, dst[223:192]}, {224'd0, 32'h5F7F_FFFF});

    run("R3 R4 merge", 2'd2, 1, 8'b1010_0011, 0, 0, 0, 2'd0, 2'd0, 4'hF);
    run("R3 R4 zero", 2'd2, 1, 8'b0101_1100, 1, 0, 0, 2'd0, 2'd0, 4'hF);
    run("R9 masked inexact", 2'd2, 1, 8'b1000_0011, 0, 0, 0, 2'd0, 2'd0, 4'hF);
    check("R9 flag clear", {255'd0, inexact}, 256'd0);

    run("R5 two lanes", 2'd0, 0, 8'h00, 0, 0, 0, 2'd0, 2'd0, 4'hF);
    run("R5 four lanes", 2'd1, 1, 8'hF5, 0, 0, 0, 2'd0, 2'd2, 4'hF);

    run("R6 override", 2'd2, 0, 8'h00, 0, 1, 0, 2'd2, 2'd3, 4'hF);
    run("R6 no override 256", 2'd1, 0, 8'h00, 0, 1, 0, 2'd2, 2'd3, 4'hF);
    src[63:0] = 64'h0000_0001_0000_0101;
    run("R7 R6 broadcast", 2'd2, 1, 8'h7E, 1, 1, 1, 2'd2, 2'd3, 4'hF);
    run("R7 broadcast merge", 2'd1, 1, 8'h05, 0, 1, 1, 2'd3, 2'd2, 4'hF);

    run("R8 reject", 2'd2, 0, 8'h00, 0, 0, 0, 2'd0, 2'd0, 4'hE);
    run("R8 reject 0", 2'd0, 1, 8'h01, 1, 0, 0, 2'd0, 2'd2, 4'h0);

    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 8; j++)
        src[64*j +: 64] = {$urandom, $urandom} >> ($urandom % 64);
      old_dst = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      run("R1 R2 R3 R4 R9 mix", 2'(k % 4), k[0], 8'($urandom), k[1], k[2], k[3],
          2'($urandom), 2'($urandom), 4'hF);
    end
    @(negedge clk);
    check("R1 idle after", {255'd0, out_valid}, 256'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule